// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

A small fully associative buffer that caches virtual-to-physical page translations for a core. Each slot stores a virtual page number, a physical page number, an 8-bit address space tag, a global flag and a valid bit. A combinational lookup port returns a hit and the physical page in the same cycle as the query. A fill port installs one translation per cycle.

A context switch is signalled by a write to the page-table base port, which carries the incoming process's address space tag. A mode input selects the switch policy. In flush mode the write drops every non-global slot. In tagged mode the write only loads the new current tag, and stale slots are kept apart from the new process by tag comparison. A separate flush-all input clears every slot, global ones included.

Top module: `tlb_asid_top`

## Requirements
- R1: After reset no slot is valid, so every lookup misses, and the current tag reads 0.
- R2: Lookup is combinational. `lk_hit_o` and `lk_ppn_o` reflect the state before the current clock edge. When several slots match, the lowest-index slot supplies the physical page.
- R3: With `asid_mode_i`=1, a non-global slot matches only if its page number equals `lk_vpn_i` and its tag equals the current tag.
- R4: A global slot matches on page number alone, in either mode.
- R5: With `asid_mode_i`=0, slot tags are ignored and a slot matches on page number alone.
- R6: A write on `ptb_we_i` with `asid_mode_i`=0 clears the valid bit of every non-global slot and keeps global slots valid.
- R7: A write on `ptb_we_i` loads `ptb_asid_i` into the current tag, visible from the next cycle. With `asid_mode_i`=1 it invalidates nothing.
- R8: `flush_all_i` clears every valid bit, global slots included, in one cycle.
- R9: A fill writes the lowest-index slot that is invalid after any same-cycle flush.
- R10: When all slots are valid, a fill replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping after the last slot, only on such a replacement.
- R11: A flush and a fill in the same cycle take effect as the flush first, then the fill. A same-cycle fill therefore survives the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid_mode_i | input | 1 | Switch policy: 0 flush non-global on base write, 1 keep slots and tag-match |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | 20 | Physical page of the hit; don't-care on a miss |
| ptb_we_i | input | 1 | Page-table base write strobe (context switch) |
| ptb_asid_i | input | 8 | Address space tag of the incoming process |
| cur_asid_o | output | 8 | Current address space tag |
| flush_all_i | input | 1 | Invalidate every slot |
| fill_i | input | 1 | Install one translation |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_ppn_i | input | 20 | Fill physical page number |
| fill_asid_i | input | 8 | Fill address space tag |
| fill_global_i | input | 1 | Fill marks the slot global |

## Verification
The assertions assume that every strobe input is a clean 0 or 1 on each rising edge, and that `asid_mode_i` is stable across the cycle in which it is sampled. Under these conditions the effect of a base write or a flush follows from a single edge. The bench changes all inputs only on falling edges. It deliberately installs duplicate page numbers and repeats tags, so that the lowest-index rule and the tag filtering are exercised rather than left untested. Flush and fill strobes are also overlapped on purpose, so that every ordering case of R11 occurs.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    SW_FLUSH = 1'b0,
    SW_TAGGED = 1'b1
  } sw_mode_e;
endpackage

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0]             glob_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]         key_vpn_i,
  input  logic [ASID_W-1:0]        key_asid_i,
  input  logic                     use_asid_i,
  output logic [N-1:0]             match_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic tag_ok;
    assign tag_ok     = glob_i[g] | ~use_asid_i | (asid_i[g] == key_asid_i);
    assign match_o[g] = valid_i[g] & tag_ok & (vpn_i[g] == key_vpn_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  free_i,
  input  logic          alloc_i,
  output logic [IW-1:0] idx_o
);
  logic          free_found;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rr_q;

  tlb_prio #(.N(N)) u_free (
    .vec_i  (free_i),
    .found_o(free_found),
    .idx_o  (free_idx)
  );

  assign idx_o = free_found ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc_i && !free_found) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_asid_top.sv
module tlb_asid_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              asid_mode_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              lk_hit_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  input  logic              ptb_we_i,
  input  logic [ASID_W-1:0] ptb_asid_i,
  output logic [ASID_W-1:0] cur_asid_o,
  input  logic              flush_all_i,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_global_i
);
  logic [ENTRIES-1:0]             valid_q, glob_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ASID_W-1:0]              cur_asid_q;

  logic [ENTRIES-1:0] match, valid_flushed, valid_d;
  logic [IW-1:0]      hit_idx, vic_idx;
  sw_mode_e           mode;

  assign mode = sw_mode_e'(asid_mode_i);

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
    .valid_i   (valid_q),
    .glob_i    (glob_q),
    .vpn_i     (vpn_q),
    .asid_i    (asid_q),
    .key_vpn_i (lk_vpn_i),
    .key_asid_i(cur_asid_q),
    .use_asid_i(mode == SW_TAGGED),
    .match_o   (match)
  );

  tlb_prio #(.N(ENTRIES)) u_hit (
    .vec_i  (match),
    .found_o(lk_hit_o),
    .idx_o  (hit_idx)
  );

  assign lk_ppn_o   = ppn_q[hit_idx];
  assign cur_asid_o = cur_asid_q;

  // flush is applied before the fill chooses its slot
  always_comb begin
    valid_flushed = valid_q;
    if (flush_all_i)                           valid_flushed = '0;
    else if (ptb_we_i && mode == SW_FLUSH)     valid_flushed = valid_q & glob_q;
    valid_d = valid_flushed;
    if (fill_i) valid_d[vic_idx] = 1'b1;
  end

  tlb_victim #(.N(ENTRIES)) u_vic (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .free_i (~valid_flushed),
    .alloc_i(fill_i),
    .idx_o  (vic_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      cur_asid_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (ptb_we_i) cur_asid_q <= ptb_asid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= '0;
      vpn_q  <= '0;
      ppn_q  <= '0;
      asid_q <= '0;
    end else if (fill_i) begin
      glob_q[vic_idx] <= fill_global_i;
      vpn_q[vic_idx]  <= fill_vpn_i;
      ppn_q[vic_idx]  <= fill_ppn_i;
      asid_q[vic_idx] <= fill_asid_i;
    end
  end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               asid_mode_i,
  input logic               lk_hit_o,
  input logic               ptb_we_i,
  input logic [ASID_W-1:0]  ptb_asid_i,
  input logic [ASID_W-1:0]  cur_asid_o,
  input logic               flush_all_i,
  input logic               fill_i,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] glob_q
);
  p_empty_miss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == '0) |-> !lk_hit_o);

  p_flush_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !fill_i) |=> (valid_q == '0) && !lk_hit_o);

  p_asid_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptb_we_i |=> cur_asid_o == $past(ptb_asid_i));

  p_tagged_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptb_we_i && asid_mode_i && !flush_all_i && !fill_i) |=> $stable(valid_q));

  p_global_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptb_we_i && !asid_mode_i && !flush_all_i && !fill_i)
      |=> valid_q == $past(valid_q & glob_q));

  p_fill_grow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_all_i && !ptb_we_i && !(&valid_q))
      |=> $countones(valid_q) == $countones($past(valid_q)) + 1);

  p_fill_after_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && flush_all_i) |=> $countones(valid_q) == 1);
endmodule

bind tlb_asid_top tlb_asid_chk #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .asid_mode_i(asid_mode_i),
  .lk_hit_o   (lk_hit_o),
  .ptb_we_i   (ptb_we_i),
  .ptb_asid_i (ptb_asid_i),
  .cur_asid_o (cur_asid_o),
  .flush_all_i(flush_all_i),
  .fill_i     (fill_i),
  .valid_q    (valid_q),
  .glob_q     (glob_q)
);

// File: tb/sim_tlb_asid_top.sv
module sim_tlb_asid_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        asid_mode_i = 1'b0;
  logic [19:0] lk_vpn_i = '0;
  logic        lk_hit_o;
  logic [19:0] lk_ppn_o;
  logic        ptb_we_i = 1'b0;
  logic [7:0]  ptb_asid_i = '0;
  logic [7:0]  cur_asid_o;
  logic        flush_all_i = 1'b0;
  logic        fill_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_ppn_i = '0;
  logic [7:0]  fill_asid_i = '0;
  logic        fill_global_i = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  bit          m_v [N];
  bit          m_g [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_ppn [N];
  logic [7:0]  m_asid [N];
  int          m_rr = 0;
  logic [7:0]  m_cur = '0;

  always #10 clk = ~clk;

  tlb_asid_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .asid_mode_i(asid_mode_i),
    .lk_vpn_i(lk_vpn_i), .lk_hit_o(lk_hit_o), .lk_ppn_o(lk_ppn_o),
    .ptb_we_i(ptb_we_i), .ptb_asid_i(ptb_asid_i), .cur_asid_o(cur_asid_o),
    .flush_all_i(flush_all_i), .fill_i(fill_i), .fill_vpn_i(fill_vpn_i),
    .fill_ppn_i(fill_ppn_i), .fill_asid_i(fill_asid_i),
    .fill_global_i(fill_global_i)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit          e_hit = 0;
    logic [19:0] e_ppn = '0;
    int          vic;
    #1;
    for (int i = 0; i < N; i++) begin
      if (!e_hit && m_v[i] && m_vpn[i] == lk_vpn_i &&
          (m_g[i] || !asid_mode_i || m_asid[i] == m_cur)) begin
        e_hit = 1; e_ppn = m_ppn[i];
      end
    end
    chk(tag, "hit", 32'(lk_hit_o), 32'(e_hit));
    if (e_hit) chk(tag, "ppn", 32'(lk_ppn_o), 32'(e_ppn));
    chk(tag, "cur_asid", 32'(cur_asid_o), 32'(m_cur));
    @(posedge clk);
    if (flush_all_i) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (ptb_we_i && !asid_mode_i) begin
      for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 0;
    end
    if (ptb_we_i) m_cur = ptb_asid_i;
    if (fill_i) begin
      vic = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
      if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % N; end
      m_v[vic] = 1; m_g[vic] = fill_global_i; m_vpn[vic] = fill_vpn_i;
      m_ppn[vic] = fill_ppn_i; m_asid[vic] = fill_asid_i;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    ptb_we_i = 0; flush_all_i = 0; fill_i = 0;
  endtask

  task automatic look(input logic [19:0] v, input string tag);
    idle(); lk_vpn_i = v; step(tag);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p,
                      input logic [7:0] a, input bit g, input string tag);
    idle(); fill_i = 1; fill_vpn_i = v; fill_ppn_i = p;
    fill_asid_i = a; fill_global_i = g; step(tag);
  endtask

  task automatic sw(input logic [7:0] a, input string tag);
    idle(); ptb_we_i = 1; ptb_asid_i = a; step(tag);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int v = 0; v < 4; v++) look(20'(v), "R1");

    asid_mode_i = 1;
    fill(20'h5, 20'hAAAAA, 8'h1, 0, "R9");
    fill(20'h5, 20'hBBBBB, 8'h2, 0, "R9");
    fill(20'h7, 20'hC0C0C, 8'h3, 1, "R9");
    sw(8'h1, "R7");
    look(20'h5, "R3");
    look(20'h7, "R4");
    sw(8'h2, "R7");
    look(20'h5, "R3");
    look(20'h7, "R4");
    look(20'h9, "R2");
    sw(8'h9, "R7");
    look(20'h5, "R3");

    asid_mode_i = 0;
    look(20'h5, "R5");
    look(20'h5, "R2");
    sw(8'h4, "R6");
    look(20'h7, "R6");
    look(20'h5, "R6");

    for (int i = 0; i < 20; i++)
      fill(20'(100 + i), 20'(32'h50000 + i), 8'h4, 0, i < 15 ? "R9" : "R10");
    for (int i = 0; i < 20; i++) look(20'(100 + i), "R10");
    look(20'h7, "R10");

    idle(); flush_all_i = 1; fill_i = 1; fill_vpn_i = 20'h33;
    fill_ppn_i = 20'h12345; fill_asid_i = 8'h4; fill_global_i = 0;
    lk_vpn_i = 20'h7; step("R11");
    look(20'h33, "R11");
    look(20'h7, "R11");
    fill(20'h7, 20'h77777, 8'h0, 1, "R9");
    idle(); ptb_we_i = 1; ptb_asid_i = 8'h6; fill_i = 1; fill_vpn_i = 20'h44;
    fill_ppn_i = 20'h44444; fill_asid_i = 8'h6; fill_global_i = 0;
    step("R11");
    look(20'h44, "R11");
    look(20'h33, "R11");
    look(20'h7, "R4");

    idle(); flush_all_i = 1; step("R8");
    look(20'h7, "R8");
    look(20'h44, "R8");

    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom_range(0, 99));
      idle();
      asid_mode_i = ($urandom_range(0, 7) != 0);
      lk_vpn_i    = 20'($urandom_range(0, 11));
      ptb_we_i    = (r < 8);
      ptb_asid_i  = 8'($urandom_range(0, 3));
      flush_all_i = (r >= 8 && r < 10) || r == 99;
      fill_i      = ($urandom_range(0, 2) == 0);
      fill_vpn_i  = 20'($urandom_range(0, 11));
      fill_ppn_i  = 20'($urandom);
      fill_asid_i = 8'($urandom_range(0, 3));
      fill_global_i = ($urandom_range(0, 5) == 0);
      step("RND");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule